// File: doc/BRIEF.md
# Host Interrupt Status and Mask Controller

This block gathers single-cycle event pulses from internal sources into a sticky status vector and decides which of them reach the host. A mask register gates each status bit: a 1 keeps that bit away from the host line. Software can load the mask whole, or flip individual mask bits through write-only set and clear ports. These ports only touch the bits written as 1, so two agents never race on a read-modify-write.

Status has two read views. A peek view leaves the status unchanged. A take view returns the status and then empties it. Software can also retire individual bits through a write-one-to-clear acknowledge port. The host interrupt line is the OR of all unmasked active status bits, and a configuration input sets its polarity. The register port is a plain request strobe with a write enable. Read data is combinational from the address in the same cycle, and any register update lands on the next rising clock edge.

Top module: `hirq_ctrl`

## Requirements
- R1: Only the implemented event bits capture events. These are bits 0 to 10, 14, 16 and 17, which gives the mask 0x0003_47FF. Events on any other bit are ignored, and those bits always read 0 in the status and in the mask.
- R2: After reset, the mask reads 0x0000_0001 and the status reads 0.
- R3: A write to the mask address (2'd0 of addr_i=3'd0) loads the mask with the written data, keeping the implemented bits only.
- R4: A write to the set port (addr_i=3'd1) sets every mask bit written as 1 and leaves every other mask bit unchanged.
- R5: A write to the clear port (addr_i=3'd2) clears every mask bit written as 1 and leaves every other mask bit unchanged.
- R6: A read of the peek view (addr_i=3'd3) returns the status and leaves it unchanged.
- R7: A read of the take view (addr_i=3'd4) returns the status and clears every status bit at the next edge.
- R8: A write to the acknowledge port (addr_i=3'd5) clears each status bit written as 1. The cleared bits then read 0 in both views.
- R9: A status bit set by a one-cycle event pulse stays set until it is acknowledged or taken.
- R10: When an event arrives in the same cycle as an acknowledge or take of its bit, the event wins and the bit stays set.
- R11: irq_o is active while any status bit is 1 and its mask bit is 0. The line is active-high when irq_low_i=0 and active-low when irq_low_i=1.
- R12: The write-only ports (addresses 1, 2 and 5) read 0. Writes to the peek and take addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | AW | Register address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid while a read is requested |
| evt_i | input | DW | One-cycle event pulses, one per bit |
| irq_low_i | input | 1 | Output polarity: 1 = active low |
| irq_o | output | 1 | Host interrupt line |

## Verification
An incoming event pulse can coincide with the removal of the same status bit, either by an acknowledge write or by a take read. The bench raises an event on a bit in the very cycle it acknowledges that bit, and later pulses a different event during a take read. It then expects the acknowledged bit to survive. It also expects the take read to return the old status, and the following peek to show only the newly arrived bit.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int BIT_RX0   = 0;
  localparam int BIT_CMPL  = 10;
  localparam int BIT_INIT  = 14;
  localparam int BIT_SNS_E = 16;
  localparam int BIT_SNS_D = 17;

  // bits 0..10 contiguous, plus init and coexistence sense pair
  localparam logic [31:0] EVT_VALID =
      ((32'h1 << (BIT_CMPL + 1)) - (32'h1 << BIT_RX0)) |
      (32'h1 << BIT_INIT) | (32'h1 << BIT_SNS_E) | (32'h1 << BIT_SNS_D);

  localparam int ADR_MASK = 0;
  localparam int ADR_MSET = 1;
  localparam int ADR_MCLR = 2;
  localparam int ADR_PEEK = 3;
  localparam int ADR_TAKE = 4;
  localparam int ADR_ACK  = 5;

  typedef struct packed {
    logic mask_wr;
    logic mask_set;
    logic mask_clr;
    logic ack_wr;
    logic take_rd;
  } strobe_t;
endpackage

// File: rtl/hirq_regdec.sv
module hirq_regdec
  import hirq_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  output strobe_t       stb_o
);
  logic wr, rd;
  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  always_comb begin
    stb_o          = '0;
    stb_o.mask_wr  = wr && (addr_i == AW'(ADR_MASK));
    stb_o.mask_set = wr && (addr_i == AW'(ADR_MSET));
    stb_o.mask_clr = wr && (addr_i == AW'(ADR_MCLR));
    stb_o.ack_wr   = wr && (addr_i == AW'(ADR_ACK));
    stb_o.take_rd  = rd && (addr_i == AW'(ADR_TAKE));
  end
endmodule

// File: rtl/hirq_mask.sv
module hirq_mask #(
  parameter int              DW  = 32,
  parameter logic [DW-1:0]   VLD = '1,
  parameter logic [DW-1:0]   RST = '0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic          set_i,
  input  logic          clr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] mask_o
);
  logic [DW-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = mask_q;
    if (wr_i)       mask_d = wdata_i;
    else if (set_i) mask_d = mask_q | wdata_i;
    else if (clr_i) mask_d = mask_q & ~wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= RST & VLD;
    else         mask_q <= mask_d & VLD;
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/hirq_status.sv
module hirq_status #(
  parameter int            DW  = 32,
  parameter logic [DW-1:0] VLD = '1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] evt_i,
  input  logic [DW-1:0] ack_i,
  input  logic          take_i,
  output logic [DW-1:0] stat_o
);
  logic [DW-1:0] stat_q, drop;

  assign drop = ack_i | {DW{take_i}};

  // new events override any same-cycle removal
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= ((stat_q & ~drop) | evt_i) & VLD;
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/hirq_ctrl.sv
module hirq_ctrl
  import hirq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic [DW-1:0] evt_i,
  input  logic          irq_low_i,
  output logic          irq_o
);
  localparam logic [DW-1:0] VLD      = DW'(EVT_VALID);
  localparam logic [DW-1:0] MASK_RST = DW'(1);

  strobe_t       stb;
  logic [DW-1:0] stat_q, mask_q;
  logic          pend;

  hirq_regdec #(.AW(AW)) u_dec (
    .req_i (req_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .stb_o (stb)
  );

  hirq_mask #(.DW(DW), .VLD(VLD), .RST(MASK_RST)) u_mask (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (stb.mask_wr),
    .set_i  (stb.mask_set),
    .clr_i  (stb.mask_clr),
    .wdata_i(wdata_i),
    .mask_o (mask_q)
  );

  hirq_status #(.DW(DW), .VLD(VLD)) u_stat (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .evt_i (evt_i),
    .ack_i (stb.ack_wr ? wdata_i : '0),
    .take_i(stb.take_rd),
    .stat_o(stat_q)
  );

  always_comb begin
    rdata_o = '0;
    if (req_i && !we_i) begin
      if (addr_i == AW'(ADR_MASK)) rdata_o = mask_q;
      else if (addr_i == AW'(ADR_PEEK) || addr_i == AW'(ADR_TAKE)) rdata_o = stat_q;
    end
  end

  assign pend  = |(stat_q & ~mask_q);
  assign irq_o = pend ^ irq_low_i;
endmodule

// File: rtl/hirq_ctrl_chk.sv
module hirq_ctrl_chk
  import hirq_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic          we_i,
  input logic [AW-1:0] addr_i,
  input logic [DW-1:0] wdata_i,
  input logic [DW-1:0] evt_i,
  input logic          irq_low_i,
  input logic          irq_o,
  input logic [DW-1:0] stat_q,
  input logic [DW-1:0] mask_q
);
  localparam logic [DW-1:0] VLD = DW'(EVT_VALID);

  logic wr_ack, rd_take, wr_set, wr_clr;
  assign wr_ack  = req_i && we_i && addr_i == AW'(ADR_ACK);
  assign rd_take = req_i && !we_i && addr_i == AW'(ADR_TAKE);
  assign wr_set  = req_i && we_i && addr_i == AW'(ADR_MSET);
  assign wr_clr  = req_i && we_i && addr_i == AW'(ADR_MCLR);

  p_reserved_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((stat_q | mask_q) & ~VLD) == '0);

  p_mask_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_set |=> (mask_q & $past(wdata_i & VLD)) == $past(wdata_i & VLD));

  p_mask_clr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_clr |=> (mask_q & $past(wdata_i)) == '0);

  p_take_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_take |=> stat_q == $past(evt_i & VLD));

  p_ack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_ack |=> (stat_q & $past(wdata_i & ~evt_i)) == '0);

  p_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_ack || rd_take) |=> (stat_q & $past(stat_q)) == $past(stat_q));

  p_evt_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(evt_i & VLD)) |=> (stat_q & $past(evt_i & VLD)) == $past(evt_i & VLD));

  p_irq_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == ((|(stat_q & ~mask_q)) ^ irq_low_i));
endmodule

bind hirq_ctrl hirq_ctrl_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .req_i    (req_i),
  .we_i     (we_i),
  .addr_i   (addr_i),
  .wdata_i  (wdata_i),
  .evt_i    (evt_i),
  .irq_low_i(irq_low_i),
  .irq_o    (irq_o),
  .stat_q   (stat_q),
  .mask_q   (mask_q)
);

// File: tb/hirq_ctrl_bench.sv
`timescale 1ns/1ps
module hirq_ctrl_bench;
  localparam int DW = 32;
  localparam int AW = 3;
  localparam logic [2:0] A_MASK = 3'd0, A_MSET = 3'd1, A_MCLR = 3'd2,
                         A_PEEK = 3'd3, A_TAKE = 3'd4, A_ACK = 3'd5;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          req_i = 1'b0;
  logic          we_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic [DW-1:0] evt_i = '0;
  logic          irq_low_i = 1'b0;
  logic          irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [DW-1:0] exp;
    string         tag;
  } item_t;
  item_t sb[$];

  always #2 clk_i = ~clk_i;

  hirq_ctrl #(.DW(DW), .AW(AW)) u_hirq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .evt_i(evt_i), .irq_low_i(irq_low_i), .irq_o(irq_o)
  );

  // monitor: reads are sampled mid-cycle
  always @(negedge clk_i) begin
    if (rst_ni && req_i && !we_i) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", rdata_o);
      end else begin
        item_t it;
        it = sb.pop_front();
        if (rdata_o !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, rdata_o, it.exp);
        end
      end
    end
  end

  task automatic op(input bit w, input logic [2:0] a, input logic [DW-1:0] d,
                    input logic [DW-1:0] e, input bit r);
    req_i = r; we_i = w; addr_i = a; wdata_i = d; evt_i = e;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0; wdata_i = '0; evt_i = '0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [DW-1:0] d, input logic [DW-1:0] e = '0);
    op(1'b1, a, d, e, 1'b1);
  endtask

  task automatic rd(input logic [2:0] a, input logic [DW-1:0] exp, input string tag,
                    input logic [DW-1:0] e = '0);
    item_t it;
    it.exp = exp; it.tag = tag;
    sb.push_back(it);
    op(1'b0, a, '0, e, 1'b1);
  endtask

  task automatic pulse(input logic [DW-1:0] e);
    op(1'b0, 3'd0, '0, e, 1'b0);
  endtask

  task automatic chk_irq(input logic exp, input string tag);
    #0.5;
    checks++;
    if (irq_o !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, irq_o, exp);
    end
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;
    @(posedge clk_i); #1;
    // R2 reset values
    rd(A_PEEK, 32'h0, "R2 status reset");
    rd(A_MASK, 32'h1, "R2 mask reset");
    chk_irq(1'b0, "R11 idle line");
    // R1 / R9 capture of all event lines
    pulse(32'hFFFF_FFFF);
    rd(A_PEEK, 32'h0003_47FF, "R1 implemented bits only");
    pulse('0); pulse('0);
    rd(A_PEEK, 32'h0003_47FF, "R9 sticky after idle");
    rd(A_PEEK, 32'h0003_47FF, "R6 peek non-destructive");
    chk_irq(1'b1, "R11 unmasked pending");
    // R3 whole mask
    wr(A_MASK, 32'hFFFF_FFFF);
    rd(A_MASK, 32'h0003_47FF, "R3 mask load");
    chk_irq(1'b0, "R11 all masked");
    irq_low_i = 1'b1;
    chk_irq(1'b1, "R11 active-low idle");
    irq_low_i = 1'b0;
    // R5 / R4 single-bit changes
    wr(A_MCLR, 32'h0000_0400);
    rd(A_MASK, 32'h0003_43FF, "R5 mask clear bit10");
    chk_irq(1'b1, "R11 bit10 unmasked");
    irq_low_i = 1'b1;
    chk_irq(1'b0, "R11 active-low asserted");
    irq_low_i = 1'b0;
    wr(A_MSET, 32'h0000_0400);
    rd(A_MASK, 32'h0003_47FF, "R4 mask set bit10");
    rd(A_MSET, 32'h0, "R12 set port reads 0");
    rd(A_ACK, 32'h0, "R12 ack port reads 0");
    // R8 acknowledge
    wr(A_ACK, 32'h0000_0003);
    rd(A_PEEK, 32'h0003_47FC, "R8 ack clears bits 0,1");
    // R7 take
    rd(A_TAKE, 32'h0003_47FC, "R7 take returns status");
    rd(A_PEEK, 32'h0, "R7 status empty after take");
    // R10 event beats same-cycle removal
    pulse(32'h0000_0020);
    wr(A_ACK, 32'h0000_0020, 32'h0000_0020);
    rd(A_PEEK, 32'h0000_0020, "R10 event beats ack");
    rd(A_TAKE, 32'h0000_0020, "R10 take returns old", 32'h0000_0002);
    rd(A_PEEK, 32'h0000_0002, "R10 event beats take");
    // R12 writes to read views ignored
    wr(A_PEEK, 32'hFFFF_FFFF);
    wr(A_TAKE, 32'hFFFF_FFFF);
    rd(A_PEEK, 32'h0000_0002, "R12 write to status views ignored");
    wr(A_MASK, 32'h0);
    chk_irq(1'b1, "R11 bit1 pending mask 0");
    wr(A_ACK, 32'h0000_0002);
    chk_irq(1'b0, "R8 ack drops line");
    @(posedge clk_i); #1;
    checks++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d left expected 0", sb.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule